// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Force

This block collects interrupt requests for levels 1 to 15 and presents one 4-bit level to a processor. Peripherals raise a level with a one-cycle pulse on its request line, and the level is held in a pending register until it is serviced. Software can also raise any level directly through a force register. A mask register selects which levels may reach the processor. The output is always the highest level that is enabled and either pending or forced, or 0 when there is none.

When the processor takes an interrupt, it returns an acknowledge strobe together with the level it took. The block then retires exactly one source for that level. If the force bit for that level is set, the force bit is cleared. Only when no force bit is set is the pending bit cleared. Software can also drop pending bits in bulk by writing a clear word. All registers sit on a simple 32-bit bus with a single-cycle write and a combinational read.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Register decode on the low address byte: mask at 0x90, pending at 0x94, force at 0x98, clear at 0x9C. Mask, pending and force read back their stored value in bits 15:0, and the upper read bits are zero.
- R2: A force write stores data bits 15:1. Bit 0 of every register reads as 0, and a request on line 0 has no effect on the pending value read back.
- R3: A mask write stores only data bits 14:1. Writing all ones reads back as 0x7FFE, so level 15 can never be enabled.
- R4: `irq_level` equals the highest index n in 1..15 with bit n set in (pending OR force) AND mask, and it is 0 when no such bit exists. It reflects a register change from the clock edge that made the change.
- R5: A one-cycle pulse on `irq_req[n]` sets pending bit n, and the bit stays set afterwards.
- R6: A write to the clear offset clears every pending bit whose data bit is 1 and leaves the other pending bits unchanged. The pending register itself cannot be written.
- R7: An acknowledge of level n clears force bit n if it is set and leaves pending bit n alone. If force bit n is clear, the acknowledge clears pending bit n instead. An acknowledge of level 0 changes nothing.
- R8: After reset, pending, mask and force all read 0 and `irq_level` is 0.
- R9: If a request for level n arrives in the same cycle as a clear write that covers n, the request wins and pending bit n stays set.
- R10: A read of the clear offset or of any unmapped offset returns 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_req | input | 16 | Per-level request pulses; bit 0 is unused |
| ack_valid | input | 1 | Acknowledge strobe from the processor |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest enabled active level, 0 if none |

## Verification
The priority encoder is checked in two full sweeps. In the first, every force pattern over bits 15:1 is applied with all maskable levels enabled. This exercises the choice of the highest bit and the exclusion of level 15. In the second, every mask pattern is applied with all levels forced, so mask gating is tested apart from the source registers. Separate directed patterns cover the remaining behaviour:
- Each of the fifteen request lines is pulsed in turn.
- Clear words with alternating bits are written.
- Acknowledges are sent to a level that is both forced and pending, which shows whether force is retired before pending.
- A request collides with a clear of the same level.
- Unmapped reads and writes are issued, which would expose a decode that aliases onto a real register.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LEVELS = 16,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h90,
  parameter logic [ADDR_W-1:0] PEND_OFS  = 8'h94,
  parameter logic [ADDR_W-1:0] FORCE_OFS = 8'h98,
  parameter logic [ADDR_W-1:0] CLR_OFS   = 8'h9C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LEVELS-1:0] irq_req,
  input  logic              ack_valid,
  input  logic [$clog2(LEVELS)-1:0] ack_level,
  output logic [$clog2(LEVELS)-1:0] irq_level
);
  localparam int LW = $clog2(LEVELS);
  localparam logic [LEVELS-1:0] LIVE = {{(LEVELS-1){1'b1}}, 1'b0};
  localparam logic [LEVELS-1:0] MASKABLE = LIVE & ~(LEVELS'(1) << (LEVELS-1));

  logic [LEVELS-1:0] pend_q, mask_q, force_q;

  wire wr        = bus_sel & bus_we;
  wire wr_mask   = wr && (bus_addr == MASK_OFS);
  wire wr_force  = wr && (bus_addr == FORCE_OFS);
  wire wr_clr    = wr && (bus_addr == CLR_OFS);

  wire [LEVELS-1:0] wlev    = bus_wdata[LEVELS-1:0];
  wire [LEVELS-1:0] ack_vec = ack_valid ? (LEVELS'(1) << ack_level) & LIVE : '0;
  wire [LEVELS-1:0] ack_f   = ack_vec & force_q;
  wire [LEVELS-1:0] ack_p   = ack_vec & ~force_q;
  wire [LEVELS-1:0] clr_vec = wr_clr ? wlev : '0;
  wire [LEVELS-1:0] active  = (pend_q | force_q) & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '0;
      force_q <= '0;
    end else begin
      pend_q  <= (pend_q & ~clr_vec & ~ack_p) | (irq_req & LIVE);
      force_q <= wr_force ? (wlev & LIVE) : (force_q & ~ack_f);
      if (wr_mask) mask_q <= wlev & MASKABLE;
    end
  end

  always_comb begin
    irq_level = '0;
    for (int i = 1; i < LEVELS; i++)
      if (active[i]) irq_level = LW'(i);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        MASK_OFS:  bus_rdata[LEVELS-1:0] = mask_q;
        PEND_OFS:  bus_rdata[LEVELS-1:0] = pend_q;
        FORCE_OFS: bus_rdata[LEVELS-1:0] = force_q;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LEVELS = 16,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h90,
  parameter logic [ADDR_W-1:0] FORCE_OFS = 8'h98,
  parameter logic [ADDR_W-1:0] CLR_OFS   = 8'h9C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [LEVELS-1:0] irq_req,
  input logic              ack_valid,
  input logic [$clog2(LEVELS)-1:0] ack_level,
  input logic [$clog2(LEVELS)-1:0] irq_level,
  input logic [LEVELS-1:0] pend_q,
  input logic [LEVELS-1:0] mask_q,
  input logic [LEVELS-1:0] force_q
);
  localparam logic [LEVELS-1:0] LIVE = {{(LEVELS-1){1'b1}}, 1'b0};
  localparam logic [LEVELS-1:0] MASKABLE = LIVE & ~(LEVELS'(1) << (LEVELS-1));

  wire wr_mask  = bus_sel && bus_we && (bus_addr == MASK_OFS);
  wire wr_force = bus_sel && bus_we && (bus_addr == FORCE_OFS);
  wire wr_clr   = bus_sel && bus_we && (bus_addr == CLR_OFS);

  // R5
  req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_req & LIVE)) |=> ((pend_q & $past(irq_req & LIVE)) == $past(irq_req & LIVE)));

  // R3
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == ($past(bus_wdata[LEVELS-1:0]) & MASKABLE)));

  // R7
  ack_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != 0 && force_q[ack_level] && !wr_force)
      |=> !force_q[$past(ack_level)]);

  // R7
  ack_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != 0 && !force_q[ack_level] && !irq_req[ack_level])
      |=> !pend_q[$past(ack_level)]);

  // R4
  level_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 0) |-> (mask_q[irq_level] && (pend_q[irq_level] || force_q[irq_level])));

  // R6
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pend_q & $past(bus_wdata[LEVELS-1:0] & ~irq_req) & LIVE) == '0));

  // R9
  clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && |(irq_req & LIVE)) |=> ((pend_q & $past(irq_req & LIVE)) == $past(irq_req & LIVE)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEVELS(LEVELS),
  .MASK_OFS(MASK_OFS), .FORCE_OFS(FORCE_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_req(irq_req),
  .ack_valid(ack_valid), .ack_level(ack_level), .irq_level(irq_level),
  .pend_q(pend_q), .mask_q(mask_q), .force_q(force_q)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_req = 0;
  logic        ack_valid = 0;
  logic [3:0]  ack_level = 0;
  logic [3:0]  irq_level;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  localparam logic [7:0] A_MASK = 8'h90, A_PEND = 8'h94, A_FORCE = 8'h98, A_CLR = 8'h9C;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level)
  );

  function automatic int top_of(int v);
    for (int i = 15; i >= 1; i--) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pulse_req(logic [15:0] r);
    @(negedge clk);
    irq_req = r;
    @(negedge clk);
    irq_req = 0;
  endtask

  task automatic ack(logic [3:0] l);
    @(negedge clk);
    ack_valid = 1; ack_level = l;
    @(negedge clk);
    ack_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    chk("R8 level", {28'd0, irq_level}, 0);
    rd(A_MASK, d);  chk("R8 mask", d, 0);
    rd(A_PEND, d);  chk("R8 pend", d, 0);
    rd(A_FORCE, d); chk("R8 force", d, 0);

    // R1 R2 R3 decode and stored widths
    wr(A_MASK, 32'hFFFF_FFFF);  rd(A_MASK, d);  chk("R3 mask width", d, 32'h7FFE);
    wr(A_FORCE, 32'hFFFF_FFFF); rd(A_FORCE, d); chk("R2 force width", d, 32'hFFFE);
    chk("R1 R4 level 14 with all forced", {28'd0, irq_level}, 14);
    wr(A_FORCE, 32'h0000_0124); rd(A_FORCE, d); chk("R1 force readback", d, 32'h124);
    wr(A_FORCE, 0);

    // R4 sweep over force patterns
    for (int v = 0; v < 32768; v++) begin
      wr(A_FORCE, v << 1);
      chk("R4 force sweep", {28'd0, irq_level}, top_of((v << 1) & 32'h7FFE));
    end
    // R4 sweep over mask patterns
    wr(A_FORCE, 32'hFFFE);
    for (int m = 0; m < 32768; m++) begin
      wr(A_MASK, m << 1);
      chk("R4 mask sweep", {28'd0, irq_level}, top_of((m << 1) & 32'h7FFE));
    end
    wr(A_FORCE, 0);
    wr(A_MASK, 32'h7FFE);

    // R2 request line 0 ignored
    pulse_req(16'h0001); rd(A_PEND, d); chk("R2 req0 ignored", d, 0);
    // R5 each request line
    for (int n = 1; n < 16; n++) begin
      pulse_req(16'(1 << n));
      rd(A_PEND, d);
      chk("R5 pending accumulates", d, ((1 << (n + 1)) - 1) & 32'hFFFE);
    end
    chk("R4 level from pending", {28'd0, irq_level}, 14);
    // R6 clear
    wr(A_CLR, 32'h5555);  rd(A_PEND, d); chk("R6 clear odd bits", d, 32'hAAAA);
    wr(A_PEND, 32'hFFFF); rd(A_PEND, d); chk("R6 pending not writable", d, 32'hAAAA);
    wr(A_CLR, 32'hFFFF);  rd(A_PEND, d); chk("R6 clear all", d, 0);
    chk("R6 level after clear", {28'd0, irq_level}, 0);

    // R7 force retired before pending
    pulse_req(16'h0020);
    wr(A_FORCE, 32'h0020);
    ack(4'd5);
    rd(A_FORCE, d); chk("R7 force cleared first", d, 0);
    rd(A_PEND, d);  chk("R7 pending kept", d, 32'h0020);
    chk("R7 level still 5", {28'd0, irq_level}, 5);
    ack(4'd5);
    rd(A_PEND, d);  chk("R7 pending cleared", d, 0);
    chk("R7 level idle", {28'd0, irq_level}, 0);
    pulse_req(16'h0004);
    ack(4'd0);
    rd(A_PEND, d);  chk("R7 ack level 0 no effect", d, 32'h0004);
    wr(A_CLR, 32'hFFFF);

    // R9 request beats clear
    pulse_req(16'h0108);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = A_CLR; bus_wdata = 32'h0108; irq_req = 16'h0100;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; irq_req = 0;
    rd(A_PEND, d); chk("R9 request wins over clear", d, 32'h0100);

    // R10 unmapped and clear reads, unmapped write
    wr(A_FORCE, 32'h0042);
    rd(A_CLR, d);  chk("R10 clear reads zero", d, 0);
    rd(8'h80, d);  chk("R10 unmapped read zero", d, 0);
    wr(8'hA0, 32'hFFFF); wr(8'h10, 32'hFFFF);
    rd(A_MASK, d);  chk("R10 mask unchanged", d, 32'h7FFE);
    rd(A_FORCE, d); chk("R10 force unchanged", d, 32'h0042);
    rd(A_PEND, d);  chk("R10 pending unchanged", d, 32'h0100);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule